// File: doc/BRIEF.md
# I2C Register-Access Transaction Dispatcher

This block sits behind an I2C target engine and turns each completed write transaction into at most one register-bus operation. Bytes arrive one at a time on a valid strobe; an end marker closes the transaction. The first byte is a compact register index. A fixed remap table turns it into a 12-bit register address and an access size. The size is 1 byte, 4 bytes, or "stream" (variable length).

A transaction holding only the index byte asks for a register read. Any further bytes are write data. Fixed-size writes are packed least significant byte first and issued as one request, but only when the data byte count equals the table size. Stream writes go out one byte per strobe, in arrival order. The target engine cannot stretch the clock, so the block paces the host another way: it drops an active-low interrupt line for exactly one cycle after each transaction whose index it recognised.

The end marker may come with the last byte, or alone in a cycle of its own. An end marker alone with no bytes before it is an empty transaction. Consecutive end markers are at least two cycles apart.

Top module: `i2c_reg_dispatch`

## Requirements
- R1: While reset is held and in the first cycle after it, `bus_valid` is 0 and `host_irq_n` is 1.
- R2: A transaction of exactly one byte whose index is in the table produces one request with `bus_write`=0, the table's address and size code, and `bus_wdata`=0. It is valid in the cycle after the end marker is sampled.
- R3: The remap table maps index to (address, size code) as follows: 0x00→(0x000,1), 0x01→(0x018,4), 0x05→(0x024,0), 0x06→(0xF00,4), 0x0A→(0x014,4), 0x0E→(0xF04,1), 0x0F→(0xF90,0). Size code 0 means stream.
- R4: A write to a fixed-size entry whose data byte count equals its size produces one request with `bus_write`=1, valid in the cycle after the end marker. Data byte k (k=0 first) sits in `bus_wdata[8k+7:8k]`, and unused bytes are 0.
- R5: A write to a fixed-size entry whose data byte count differs from its size produces no request.
- R6: Each data byte of a write to a stream entry produces one request with `bus_write`=1 and size code 0, with the byte in `bus_wdata[7:0]` and the upper bytes 0. The request is valid in the cycle after the byte is sampled. Bytes go out in order, with no length check, for 1 to 62 data bytes.
- R7: An empty transaction, or one whose index is not in the table, produces no request and no interrupt pulse.
- R8: Every transaction whose index is in the table, including one discarded under R5, drives `host_irq_n` low for exactly one cycle. That cycle is the one after the end marker is sampled.
- R9: An end marker arriving alone after the last byte closes the transaction with the same result as an end marker carried on that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received byte is present on `rx_data` |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | End of transaction; includes `rx_data` when `rx_valid` is also high |
| bus_valid | output | 1 | One-cycle register request strobe |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 12 | Wide register address |
| bus_size | output | 3 | Size code: 0 stream, 1 or 4 bytes |
| bus_wdata | output | 32 | Write data, least significant byte first |
| host_irq_n | output | 1 | Active-low flow-control pulse to the host |

## Verification
Every result is registered once. A read, a fixed-size write and the interrupt pulse are due one cycle after the edge that samples the end marker. Each stream byte's request is due one cycle after the edge that samples that byte. The bench keeps a cycle counter. It records the cycle of every edge that samples an end marker, and samples the outputs at the falling edge. Against that recorded cycle it compares the cycle in which each read, fixed write and interrupt low level appears, as well as the full ordered list of requests that a bench model predicts for the transaction.

// File: rtl/i2c_disp_pkg.sv
package i2c_disp_pkg;
  localparam int ADDR_W = 12;
  localparam int SIZE_W = 3;
  localparam int N_ENT  = 7;

  typedef struct packed {
    logic [7:0]        idx;
    logic [ADDR_W-1:0] addr;
    logic [SIZE_W-1:0] size;
  } remap_t;

  localparam logic [SIZE_W-1:0] SZ_STREAM = '0;

  // R3: compact index to wide address and size code
  localparam remap_t REMAP [N_ENT] = '{
    '{8'h00, 12'h000, 3'd1},
    '{8'h01, 12'h018, 3'd4},
    '{8'h05, 12'h024, 3'd0},
    '{8'h06, 12'hF00, 3'd4},
    '{8'h0A, 12'h014, 3'd4},
    '{8'h0E, 12'hF04, 3'd1},
    '{8'h0F, 12'hF90, 3'd0}
  };
endpackage

// File: rtl/remap_lookup.sv
module remap_lookup
  import i2c_disp_pkg::*;
(
  input  logic [7:0]        idx,
  output logic              hit,
  output logic [ADDR_W-1:0] addr,
  output logic [SIZE_W-1:0] size
);
  logic [N_ENT-1:0] match;

  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    assign match[g] = (idx == REMAP[g].idx);
  end

  always_comb begin
    hit  = |match;
    addr = '0;
    size = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (match[i]) begin
        addr = addr | REMAP[i].addr;
        size = size | REMAP[i].size;
      end
    end
  end
endmodule

// File: rtl/irq_pulser.sv
module irq_pulser (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic irq_n
);
  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~fire;
  end

  // R8: a low cycle is only ever caused by a fire request one cycle earlier
  a_r8_low_follows_fire: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> $past(fire));
endmodule

// File: rtl/i2c_reg_dispatch.sv
module i2c_reg_dispatch
  import i2c_disp_pkg::*;
#(
  parameter  int MAX_BYTES  = 63,
  parameter  int WORD_BYTES = 4,
  localparam int CNT_W      = $clog2(MAX_BYTES + 2),
  localparam int DATA_W     = 8 * WORD_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [SIZE_W-1:0] bus_size,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              host_irq_n
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0]  cnt_q;
  logic              hit_q;
  logic [ADDR_W-1:0] addr_q;
  logic [SIZE_W-1:0] size_q;
  logic [DATA_W-1:0] data_q, data_nx;

  logic              lk_hit;
  logic [ADDR_W-1:0] lk_addr;
  logic [SIZE_W-1:0] lk_size;

  logic              first, cur_hit, is_stream, end_hit;
  logic [ADDR_W-1:0] cur_addr;
  logic [SIZE_W-1:0] cur_size;
  logic [CNT_W:0]    total, dcnt;
  logic [CNT_W-1:0]  slot;

  remap_lookup i_lookup (
    .idx  (rx_data),
    .hit  (lk_hit),
    .addr (lk_addr),
    .size (lk_size)
  );

  always_comb begin
    first     = (cnt_q == '0);
    cur_hit   = first ? lk_hit  : hit_q;
    cur_addr  = first ? lk_addr : addr_q;
    cur_size  = first ? lk_size : size_q;
    is_stream = (cur_size == SZ_STREAM);
    total     = {1'b0, cnt_q} + {{CNT_W{1'b0}}, rx_valid};
    dcnt      = total - (CNT_W+1)'(1);
    slot      = cnt_q - CNT_W'(1);
    data_nx   = first ? '0 : data_q;
    if (rx_valid && !first && (slot < CNT_W'(WORD_BYTES)))
      data_nx[int'(slot)*8 +: 8] = rx_data;
    end_hit   = rx_last && (total != '0) && cur_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      hit_q     <= 1'b0;
      addr_q    <= '0;
      size_q    <= '0;
      data_q    <= '0;
      bus_valid <= 1'b0;
      bus_write <= 1'b0;
      bus_addr  <= '0;
      bus_size  <= '0;
      bus_wdata <= '0;
    end else begin
      bus_valid <= 1'b0;
      if (rx_valid && !first && cur_hit && is_stream) begin
        bus_valid <= 1'b1;
        bus_write <= 1'b1;
        bus_addr  <= cur_addr;
        bus_size  <= cur_size;
        bus_wdata <= DATA_W'(rx_data);
      end
      if (end_hit) begin
        if (total == (CNT_W+1)'(1)) begin
          bus_valid <= 1'b1;
          bus_write <= 1'b0;
          bus_addr  <= cur_addr;
          bus_size  <= cur_size;
          bus_wdata <= '0;
        end else if (!is_stream && dcnt == (CNT_W+1)'(cur_size)) begin
          bus_valid <= 1'b1;
          bus_write <= 1'b1;
          bus_addr  <= cur_addr;
          bus_size  <= cur_size;
          bus_wdata <= data_nx;
        end
      end
      if (rx_last) begin
        cnt_q  <= '0;
        hit_q  <= 1'b0;
        data_q <= '0;
      end else if (rx_valid) begin
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
        data_q <= data_nx;
        if (first) begin
          hit_q  <= lk_hit;
          addr_q <= lk_addr;
          size_q <= lk_size;
        end
      end
    end
  end

  irq_pulser i_irq (
    .clk   (clk),
    .rst   (rst),
    .fire  (end_hit),
    .irq_n (host_irq_n)
  );

  // R1: idle outputs right after reset
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!bus_valid && host_irq_n));
  // R2: a read only appears at the end of a transaction, with the pulse
  a_r2_read_at_end: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write) |-> ($past(rx_last) && !host_irq_n));
  // R3: only table size codes reach the bus
  a_r3_size_code: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> (bus_size == 3'd0 || bus_size == 3'd1 || bus_size == 3'd4));
  // R4: a fixed-size write only appears at the end, with the pulse
  a_r4_fixed_at_end: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && bus_size != SZ_STREAM) |-> ($past(rx_last) && !host_irq_n));
  // R6: a stream request carries one byte sampled in the previous cycle
  a_r6_stream_byte: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && bus_size == SZ_STREAM) |->
      ($past(rx_valid) && bus_wdata[DATA_W-1:8] == '0));
  // R7: a pulse needs an end marker one cycle earlier
  a_r7_pulse_needs_end: assert property (@(posedge clk) disable iff (rst)
    !host_irq_n |-> $past(rx_last));
endmodule

// File: tb/test_i2c_reg_dispatch.sv
module test_i2c_reg_dispatch;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_last = 1'b0;
  logic        bus_valid, bus_write, host_irq_n;
  logic [11:0] bus_addr;
  logic [2:0]  bus_size;
  logic [31:0] bus_wdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_reg_dispatch i_i2c_reg_dispatch (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .host_irq_n(host_irq_n)
  );

  int tests = 0, fails = 0, cyc = 0, end_cyc = -1;
  bit rec_en = 0;
  logic [7:0] pay [64];

  int obs_n, irq_cnt, irq_cyc;
  logic obs_w [80]; logic [11:0] obs_a [80]; logic [2:0] obs_s [80];
  logic [31:0] obs_d [80]; int obs_c [80];

  int exp_n, exp_irq;
  logic exp_w [80]; logic [11:0] exp_a [80]; logic [2:0] exp_s [80];
  logic [31:0] exp_d [80];
  string tag;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rec_en) begin
    if (bus_valid && obs_n < 80) begin
      obs_w[obs_n] = bus_write; obs_a[obs_n] = bus_addr; obs_s[obs_n] = bus_size;
      obs_d[obs_n] = bus_wdata; obs_c[obs_n] = cyc; obs_n++;
    end
    if (!host_irq_n) begin irq_cnt++; irq_cyc = cyc; end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  // R3 table, written from the requirement
  function automatic void tb_lookup(input logic [7:0] idx, output bit f,
                                    output logic [11:0] a, output logic [2:0] s);
    f = 1;
    case (idx)
      8'h00: begin a = 12'h000; s = 3'd1; end
      8'h01: begin a = 12'h018; s = 3'd4; end
      8'h05: begin a = 12'h024; s = 3'd0; end
      8'h06: begin a = 12'hF00; s = 3'd4; end
      8'h0A: begin a = 12'h014; s = 3'd4; end
      8'h0E: begin a = 12'hF04; s = 3'd1; end
      8'h0F: begin a = 12'hF90; s = 3'd0; end
      default: begin f = 0; a = '0; s = '0; end
    endcase
  endfunction

  task automatic build_expected(input int len);
    bit f; logic [11:0] a; logic [2:0] s;
    exp_n = 0; exp_irq = 0; tag = "R7";
    if (len == 0) return;
    tb_lookup(pay[0], f, a, s);
    if (!f) return;
    exp_irq = 1;
    if (len == 1) begin
      tag = "R2";
      exp_w[0] = 0; exp_a[0] = a; exp_s[0] = s; exp_d[0] = '0; exp_n = 1;
    end else if (s == 3'd0) begin
      tag = "R6";
      for (int i = 1; i < len; i++) begin
        exp_w[exp_n] = 1; exp_a[exp_n] = a; exp_s[exp_n] = 3'd0;
        exp_d[exp_n] = {24'h0, pay[i]}; exp_n++;
      end
    end else if (len - 1 == int'(s)) begin
      tag = "R4";
      exp_w[0] = 1; exp_a[0] = a; exp_s[0] = s; exp_d[0] = '0;
      for (int k = 0; k < int'(s); k++) exp_d[0][8*k +: 8] = pay[k+1];
      exp_n = 1;
    end else tag = "R5";
  endtask

  task automatic run_txn(input int len, input bit sep_last, input bit gaps);
    obs_n = 0; irq_cnt = 0; irq_cyc = -1; end_cyc = -1;
    build_expected(len);
    rec_en = 1;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = pay[i];
      rx_last = (i == len - 1) && !sep_last && len > 0;
      if (rx_last) end_cyc = cyc + 1;
      if (gaps && ($urandom % 3 == 0) && !rx_last) begin
        @(negedge clk); rx_valid = 0; rx_last = 0;
      end
    end
    if (sep_last || len == 0) begin
      @(negedge clk); rx_valid = 0; rx_last = 1; end_cyc = cyc + 1;
    end
    @(negedge clk); rx_valid = 0; rx_last = 0;
    repeat (3) @(negedge clk);
    rec_en = 0;
    if (sep_last) tag = {tag, "/R9"};
    chk(obs_n == exp_n, tag, "request count", obs_n, exp_n);
    for (int i = 0; i < exp_n && i < obs_n; i++) begin
      chk(obs_w[i] == exp_w[i], tag, "write flag", obs_w[i], exp_w[i]);
      chk(obs_a[i] == exp_a[i], tag, "address (R3)", obs_a[i], exp_a[i]);
      chk(obs_s[i] == exp_s[i], tag, "size code (R3)", obs_s[i], exp_s[i]);
      chk(obs_d[i] == exp_d[i], tag, "write data", obs_d[i], exp_d[i]);
    end
    if (exp_n == 1 && obs_n == 1 && (tag[1] == "2" || tag[1] == "4"))
      chk(obs_c[0] == end_cyc, tag, "request cycle", obs_c[0], end_cyc);
    chk(irq_cnt == exp_irq, "R8", "pulse count", irq_cnt, exp_irq);
    if (exp_irq == 1)
      chk(irq_cyc == end_cyc, "R8", "pulse cycle", irq_cyc, end_cyc);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit f; logic [11:0] a; logic [2:0] s;
    logic [7:0] idx_list [7] = '{8'h00, 8'h01, 8'h05, 8'h06, 8'h0A, 8'h0E, 8'h0F};
    void'($urandom(32'h1c2d));
    repeat (3) @(negedge clk);
    chk(bus_valid == 0, "R1", "bus_valid in reset", bus_valid, 0);
    chk(host_irq_n == 1, "R1", "irq in reset", host_irq_n, 1);
    @(negedge clk); rst = 0;
    @(negedge clk);
    chk(bus_valid == 0, "R1", "bus_valid after reset", bus_valid, 0);
    chk(host_irq_n == 1, "R1", "irq after reset", host_irq_n, 1);

    // R2 / R3: read every table entry
    foreach (idx_list[i]) begin pay[0] = idx_list[i]; run_txn(1, 0, 0); end
    // R4: full fixed writes, size 4 and size 1
    pay[0] = 8'h01; pay[1] = 8'h11; pay[2] = 8'h22; pay[3] = 8'h33; pay[4] = 8'h44;
    run_txn(5, 0, 0);
    pay[0] = 8'h0E; pay[1] = 8'hA5; run_txn(2, 1, 0);
    // R5: short and long writes to a 4-byte entry
    pay[0] = 8'h06; run_txn(3, 0, 0);
    run_txn(6, 0, 0);
    // R6: longest stream
    pay[0] = 8'h05;
    for (int i = 1; i < 63; i++) pay[i] = 8'(i * 7 + 3);
    run_txn(63, 0, 1);
    // R7: empty and unknown
    run_txn(0, 0, 0);
    pay[0] = 8'h02; run_txn(1, 0, 0);
    pay[0] = 8'hFF; pay[1] = 8'h12; run_txn(2, 1, 0);

    for (int t = 0; t < 200; t++) begin
      int len;
      if ($urandom % 5 == 0) pay[0] = 8'($urandom);
      else pay[0] = idx_list[$urandom % 7];
      tb_lookup(pay[0], f, a, s);
      if (f && s != 0 && ($urandom % 2 == 0)) len = int'(s) + 1;
      else if ($urandom % 10 == 0) len = 1 + int'($urandom % 63);
      else len = int'($urandom % 8);
      for (int i = 1; i < 64; i++) pay[i] = 8'($urandom);
      run_txn(len, ($urandom % 4 == 0), ($urandom % 2 == 0));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule